// File: doc/BRIEF.md
# SPI Master with Handshake-Cleared Status Flags

This block is an eight-bit serial peripheral interface master sitting on a small single-cycle register bus. Software picks a serial clock rate, sets the block to master, and writes a byte into the data register. That write starts a transfer. The byte leaves on MOSI most significant bit first, while eight bits are gathered from MISO. After the eighth serial clock cycle, the received byte becomes readable from the same data register.

Three sticky flags report progress and errors: transfer complete, write collision and mode fault. A flag cannot be cleared by one access. Software must first read the status register while the flag is set, and then make the access that belongs to that flag. For the first two flags that access is to the data register. For mode fault it is a write to the control register.

If the slave-select input is pulled low while the block is master, the block drops out of master mode. It then releases SCK and MOSI and aborts any transfer in progress.

Register map (two-bit address): 0 = control (bit 1 master, bit 0 enable), 1 = baud (prescale P in bits 6:4, rate R in bits 2:0), 2 = status, 3 = data.

Top module: `spi_flag_master`

## Requirements
- R1: After reset the status register reads 0x00. Control and baud read 0x00, and `sck`, `mosi` and `drive_en` are low.
- R2: The SCK period is (P+1)·2^(R+1) bus clocks. Over the fields this runs from 2 to 2048.
- R3: A data write while idle, enabled and master starts a transfer of exactly eight SCK pulses. SCK idles low. MOSI carries the written byte msb first and changes on falling SCK. MISO is sampled on rising SCK.
- R4: Transfer complete, read as bit 7 of the status byte (msb-numbered bit 0), sets when the eighth SCK cycle ends. The byte received from MISO is then readable at the data address.
- R5: Transfer complete clears only when a status read that saw it set is followed by a read or write of the data register.
- R6: Write collision, read as bit 6 of the status byte (msb-numbered bit 1), sets when the data register is written during a transfer. That written byte is discarded, and the running transfer shifts out and receives unchanged.
- R7: Write collision clears through the same status-read-then-data-access handshake.
- R8: Mode fault, read as bit 4 of the status byte (msb-numbered bit 3), sets when `ss_n` is low while the block is enabled master. The master control bit then reads 0, `drive_en` drops, and the transfer ends without setting transfer complete.
- R9: Mode fault clears only when a status read that saw it set is followed by a control write. Data accesses, and control writes with no prior arming read, leave it set.
- R10: A status read that sees a flag clear does not arm it. Accesses other than the flag's second step do not disarm it.
- R11: Status bits 5 and 3:0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, zero when not reading) |
| ss_n | input | 1 | Slave-select sense, low causes mode fault |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| drive_en | output | 1 | High while the block drives SCK and MOSI |

## Verification
The bench checks the divider formula at both ends and in between by measuring rising-edge spacing. A design that multiplied the fields wrongly, or counted whole periods instead of halves, would show a wrong period.

It writes the data register in the middle of a transfer. The outgoing byte must be unchanged and the collision flag must set; a design that accepted the write would corrupt MOSI.

It also runs the clearing handshake out of order. It reads status while a flag is still clear and then accesses data. It places unrelated accesses between the two steps. It follows a mode fault with data accesses, and writes control with no arming read first. A design that armed on any read, disarmed on any access, or cleared mode fault from the data register would lose a flag that should remain.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 3;
    localparam int RATE_W = 3;
    localparam int NFLAG  = 3;

    // flag vector indices
    localparam int FLG_DONE = 0;
    localparam int FLG_WCOL = 1;
    localparam int FLG_MODF = 2;

    // status byte positions, numbered from the msb
    localparam int POS_DONE = 0;
    localparam int POS_WCOL = 1;
    localparam int POS_MODF = 3;

    // baud register field placement
    localparam int BAUD_PRE_LSB  = 4;
    localparam int BAUD_RATE_LSB = 0;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BAUD = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mstr;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate;
    } baud_t;

    function automatic logic [DATA_W-1:0] pack_status(input logic [NFLAG-1:0] f);
        logic [DATA_W-1:0] s;
        s = '0;
        s[DATA_W-1-POS_DONE] = f[FLG_DONE];
        s[DATA_W-1-POS_WCOL] = f[FLG_WCOL];
        s[DATA_W-1-POS_MODF] = f[FLG_MODF];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_baud(input baud_t b);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BAUD_PRE_LSB +: PRE_W]   = b.pre;
        v[BAUD_RATE_LSB +: RATE_W] = b.rate;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[1] = c.mstr;
        v[0] = c.en;
        return v;
    endfunction

endpackage

// File: rtl/spi_fm_flag.sv
module spi_fm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic arm_rd,
    input  logic step2,
    output logic flag
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set) begin
            // a new event wins over a clear in the same cycle
            flag <= 1'b1;
            if (armed && step2) begin
                armed <= 1'b0;
            end
        end else if (armed && step2) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (arm_rd && flag) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_fm_divider.sv
module spi_fm_divider #(
    parameter int PRE_W  = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    // half period = (pre+1) << rate, largest 2^PRE_W * 2^(2^RATE_W - 1)
    localparam int CNT_W = PRE_W + (1 << RATE_W) - 1;

    logic [CNT_W:0] half_len;
    logic [CNT_W:0] half_last;
    logic [CNT_W:0] cnt_q;

    assign half_len  = ({{(CNT_W + 1 - PRE_W){1'b0}}, pre} + (CNT_W + 1)'(1)) << rate;
    assign half_last = half_len - (CNT_W + 1)'(1);
    assign tick      = run && (cnt_q == half_last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == half_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + (CNT_W + 1)'(1);
        end
    end

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] tx,
    input  logic          abort,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx
);

    localparam int CW = $clog2(DW);

    logic          busy_q;
    logic          sck_q;
    logic          rx_bit_q;
    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic          last_fall;

    assign last_fall = busy_q && tick && sck_q && (cnt_q == CW'(DW - 1));
    assign done      = last_fall && !abort;
    assign rx        = {sh_q[DW-2:0], rx_bit_q};
    assign busy      = busy_q;
    assign sck       = sck_q;
    assign mosi      = busy_q && sh_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            sck_q    <= 1'b0;
            rx_bit_q <= 1'b0;
            sh_q     <= '0;
            cnt_q    <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            sh_q   <= tx;
            cnt_q  <= '0;
        end else if (busy_q && tick) begin
            if (!sck_q) begin
                // leading (rising) edge: sample the input line
                sck_q    <= 1'b1;
                rx_bit_q <= miso;
            end else begin
                // trailing (falling) edge: advance the output bit
                sck_q <= 1'b0;
                sh_q  <= {sh_q[DW-2:0], rx_bit_q};
                if (cnt_q == CW'(DW - 1)) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spi_fm_regs.sv
module spi_fm_regs
    import spi_fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_n,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start,
    output logic [DATA_W-1:0] tx_byte,
    output baud_t             baud,
    output logic              master_on,
    output logic [NFLAG-1:0]  flags
);

    reg_sel_e          sel;
    ctrl_t             ctrl_q;
    baud_t             baud_q;
    logic [DATA_W-1:0] rx_q;
    logic              rd_acc, wr_acc;
    logic              stat_rd, data_acc, data_wr, ctrl_wr, baud_wr;
    logic              fault, collide;
    logic [NFLAG-1:0]  set_v, step_v;

    assign sel      = reg_sel_e'(bus_addr);
    assign rd_acc   = bus_sel && !bus_wr;
    assign wr_acc   = bus_sel && bus_wr;
    assign stat_rd  = rd_acc && (sel == SEL_STAT);
    assign data_acc = bus_sel && (sel == SEL_DATA);
    assign data_wr  = wr_acc && (sel == SEL_DATA);
    assign ctrl_wr  = wr_acc && (sel == SEL_CTRL);
    assign baud_wr  = wr_acc && (sel == SEL_BAUD);

    assign master_on = ctrl_q.en && ctrl_q.mstr;
    assign fault     = master_on && !ss_n;
    assign start     = data_wr && !busy && master_on && !fault;
    assign collide   = data_wr && busy;
    assign tx_byte   = bus_wdata;
    assign baud      = baud_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.mstr <= bus_wdata[1];
            ctrl_q.en   <= bus_wdata[0];
        end else if (fault) begin
            ctrl_q.mstr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= '0;
        end else if (baud_wr) begin
            baud_q.pre  <= bus_wdata[BAUD_PRE_LSB +: PRE_W];
            baud_q.rate <= bus_wdata[BAUD_RATE_LSB +: RATE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (xfer_done) begin
            rx_q <= rx_byte;
        end
    end

    // per-flag set event and second step of the clearing handshake
    assign set_v[FLG_DONE]  = xfer_done;
    assign set_v[FLG_WCOL]  = collide;
    assign set_v[FLG_MODF]  = fault;
    assign step_v[FLG_DONE] = data_acc;
    assign step_v[FLG_WCOL] = data_acc;
    assign step_v[FLG_MODF] = ctrl_wr;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        spi_fm_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set    (set_v[g]),
            .arm_rd (stat_rd),
            .step2  (step_v[g]),
            .flag   (flags[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (sel)
                SEL_CTRL: bus_rdata = pack_ctrl(ctrl_q);
                SEL_BAUD: bus_rdata = pack_baud(baud_q);
                SEL_STAT: bus_rdata = pack_status(flags);
                SEL_DATA: bus_rdata = rx_q;
            endcase
        end
    end

endmodule

// File: rtl/spi_flag_master.sv
module spi_flag_master
    import spi_fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_n,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              drive_en
);

    logic              start;
    logic [DATA_W-1:0] tx_byte;
    baud_t             baud;
    logic              master_on;
    logic [NFLAG-1:0]  flag_vec;
    logic              busy;
    logic              xfer_done;
    logic [DATA_W-1:0] rx_byte;
    logic              tick;
    logic              sck_raw;
    logic              mosi_raw;
    logic              abort;

    assign abort = !master_on;

    spi_fm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ss_n      (ss_n),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_byte   (rx_byte),
        .start     (start),
        .tx_byte   (tx_byte),
        .baud      (baud),
        .master_on (master_on),
        .flags     (flag_vec)
    );

    spi_fm_divider #(
        .PRE_W  (PRE_W),
        .RATE_W (RATE_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .pre  (baud.pre),
        .rate (baud.rate),
        .tick (tick)
    );

    spi_fm_shifter #(
        .DW (DATA_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tx    (tx_byte),
        .abort (abort),
        .tick  (tick),
        .miso  (miso),
        .busy  (busy),
        .sck   (sck_raw),
        .mosi  (mosi_raw),
        .done  (xfer_done),
        .rx    (rx_byte)
    );

    assign drive_en = master_on;
    assign sck      = sck_raw && master_on;
    assign mosi     = mosi_raw && master_on;

endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker
    import spi_fm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ss_n,
    input logic              sck,
    input logic              mosi,
    input logic              drive_en,
    input logic              busy,
    input logic              xfer_done,
    input logic [NFLAG-1:0]  flag_vec
);

    logic stat_rd, data_acc, data_wr, ctrl_wr;

    assign stat_rd  = bus_sel && !bus_wr && (bus_addr == 2'd2);
    assign data_acc = bus_sel && (bus_addr == 2'd3);
    assign data_wr  = bus_sel && bus_wr && (bus_addr == 2'd3);
    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == 2'd0);

    a_r1_lines_quiet: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (!sck && !mosi));

    a_r3_sck_only_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> busy);

    a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> flag_vec[FLG_DONE]);

    a_r5_done_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_vec[FLG_DONE]) |-> $past(data_acc));

    a_r6_wcol_sets: assert property (@(posedge clk) disable iff (rst)
        (busy && data_wr) |=> flag_vec[FLG_WCOL]);

    a_r7_wcol_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_vec[FLG_WCOL]) |-> $past(data_acc));

    a_r8_fault_release: assert property (@(posedge clk) disable iff (rst)
        (drive_en && !ss_n && !ctrl_wr) |=> (!drive_en && flag_vec[FLG_MODF]));

    a_r8_abort_stops: assert property (@(posedge clk) disable iff (rst)
        !drive_en |=> !busy);

    a_r9_modf_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_vec[FLG_MODF]) |-> $past(ctrl_wr));

    // reserved positions: value bits 5 and 3:0
    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> ((bus_rdata & 8'h2F) == 8'h00));

endmodule

bind spi_flag_master spi_fm_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ss_n      (ss_n),
    .sck       (sck),
    .mosi      (mosi),
    .drive_en  (drive_en),
    .busy      (busy),
    .xfer_done (xfer_done),
    .flag_vec  (flag_vec)
);

// File: tb/test_spi_flag_master.sv
`timescale 1ns/1ps
module test_spi_flag_master;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_BAUD = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;
    localparam int NVEC = 6;

    // {pre, rate, tx byte, slave byte}
    localparam logic [21:0] VEC [NVEC] = '{
        {3'd0, 3'd0, 8'hA5, 8'h3C},
        {3'd1, 3'd0, 8'h5A, 8'hC3},
        {3'd0, 3'd2, 8'hFF, 8'h00},
        {3'd2, 3'd1, 8'h01, 8'h80},
        {3'd3, 3'd3, 8'h6E, 8'h91},
        {3'd7, 3'd7, 8'h96, 8'h69}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    wire  [7:0] bus_rdata;
    logic       ss_n = 1'b1;
    wire        miso;
    wire        sck, mosi, drive_en;

    always #2 clk = ~clk;

    spi_flag_master i_spi_flag_master (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ss_n      (ss_n),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .drive_en  (drive_en)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model and line monitor, all evaluated at the falling bus clock
    logic       mon_clr = 1'b0;
    logic [7:0] slv_val = 8'h00;
    logic [7:0] slv_sh = 8'h00;
    logic [7:0] mosi_cap = 8'h00;
    logic       sck_d = 1'b0;
    int         rises = 0;
    int         t_first = 0;
    int         t_second = 0;

    assign miso = slv_sh[7];

    always @(negedge clk) begin
        if (mon_clr) begin
            slv_sh   = slv_val;
            mosi_cap = 8'h00;
            rises    = 0;
        end else begin
            if (sck && !sck_d) begin
                rises    = rises + 1;
                mosi_cap = {mosi_cap[6:0], mosi};
                if (rises == 1) t_first = cyc;
                else if (rises == 2) t_second = cyc;
            end
            if (!sck && sck_d) slv_sh = {slv_sh[6:0], 1'b0};
        end
        sck_d = sck;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        check(tag, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic load_slave(input logic [7:0] v);
        @(posedge clk);
        slv_val = v;
        mon_clr = 1'b1;
        @(posedge clk);
        mon_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] junk;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 sck", {31'h0, sck}, 32'h0);
        check("R1 mosi", {31'h0, mosi}, 32'h0);
        check("R1 drive_en", {31'h0, drive_en}, 32'h0);
        rd_chk("R1 status", A_STAT, 8'h00);
        rd_chk("R1 ctrl", A_CTRL, 8'h00);
        rd_chk("R1 baud", A_BAUD, 8'h00);

        bus_write(A_CTRL, 8'h03);
        check("R3 drive_en on", {31'h0, drive_en}, 32'h1);

        // vector walk: R2 period, R3 bits, R4 completion, R5 clear
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] p, r;
            logic [7:0] txb, slv;
            int half;
            {p, r, txb, slv} = VEC[i];
            half = (int'(p) + 1) << r;
            bus_write(A_BAUD, {1'b0, p, 1'b0, r});
            load_slave(slv);
            bus_write(A_DATA, txb);
            repeat (16 * half + 2) @(negedge clk);
            check("R3 sck pulses", rises, 8);
            check("R3 mosi byte", {24'h0, mosi_cap}, {24'h0, txb});
            check("R2 sck period", t_second - t_first, 2 * half);
            rd_chk("R4 done flag", A_STAT, 8'h80);
            rd_chk("R4 rx byte", A_DATA, slv);
            rd_chk("R5 cleared", A_STAT, 8'h00);
        end

        // R10 / R5: unarmed read, then intervening accesses
        bus_write(A_BAUD, 8'h11);
        load_slave(8'h22);
        bus_write(A_DATA, 8'h11);
        rd_chk("R10 early status", A_STAT, 8'h00);
        repeat (70) @(negedge clk);
        rd_chk("R10 data read", A_DATA, 8'h22);
        rd_chk("R10 r5 still set", A_STAT, 8'h80);
        bus_write(A_BAUD, 8'h11);
        rd_chk("R10 ctrl read", A_CTRL, 8'h03);
        rd_chk("R10 data read 2", A_DATA, 8'h22);
        rd_chk("R10 cleared", A_STAT, 8'h00);

        // R6 / R7 write collision
        load_slave(8'h3C);
        bus_write(A_DATA, 8'hA5);
        repeat (10) @(negedge clk);
        bus_write(A_DATA, 8'h0F);
        rd_chk("R6 wcol set", A_STAT, 8'h40);
        repeat (70) @(negedge clk);
        check("R6 pulses kept", rises, 8);
        check("R6 mosi kept", {24'h0, mosi_cap}, 32'hA5);
        rd_chk("R6 both flags", A_STAT, 8'hC0);
        rd_chk("R6 rx kept", A_DATA, 8'h3C);
        rd_chk("R7 both cleared", A_STAT, 8'h00);

        // R8 / R9 mode fault during a transfer
        load_slave(8'h00);
        bus_write(A_DATA, 8'hFF);
        repeat (10) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        check("R8 drive_en off", {31'h0, drive_en}, 32'h0);
        check("R8 sck off", {31'h0, sck}, 32'h0);
        rd_chk("R8 master bit cleared", A_CTRL, 8'h01);
        repeat (80) @(negedge clk);
        rd_chk("R8 modf only", A_STAT, 8'h10);
        bus_read(A_DATA, junk);
        rd_chk("R9 data access keeps", A_STAT, 8'h10);
        bus_write(A_CTRL, 8'h03);
        rd_chk("R9 cleared", A_STAT, 8'h00);
        check("R9 drive_en back", {31'h0, drive_en}, 32'h1);

        // R9 control write without an arming read
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        bus_write(A_CTRL, 8'h03);
        rd_chk("R9 unarmed ctrl write", A_STAT, 8'h10);
        bus_write(A_CTRL, 8'h03);
        rd_chk("R9 r11 armed clear", A_STAT, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule